// File: doc/BRIEF.md
# Condition Code Flag Generator

This block derives the negative, zero, overflow and carry flags that an arithmetic or shift step leaves behind, and keeps them in an 8-bit condition code register. The datapath next to it supplies an operation class, a width select, both operands, the result it has already formed, and, for shifts, the bit shifted out. The block does not compute the result. It works only from the sign bits of the operands and result, and from the result's zero test.

Each class changes its own subset of the four flags. Add and subtract change all four. A test changes N and Z, forces V low and leaves C alone. A shift loads C with the bit shifted out and then sets V to the new N XOR the new C. Flags are written only in a cycle where the update enable is high. The four upper register bits (S, X, H, I) are stored here but nothing in this block writes them.

Top module: `ccg_flag_unit`

## Requirements
- R1: Reset (rst_n low) sets `ccr_q` to 0xD0. The bit layout, from bit 7 down to bit 0, is S X H I N Z V C.
- R2: For add (op = 0), C becomes sign bit of ((a & b) | (b & ~r) | (a & ~r)), where "sign bit" means bit 7 when narrow and bit 15 when wide.
- R3: For add (op = 0), V becomes sign bit of ((a & b & ~r) | (~a & ~b & r)).
- R4: For subtract (op = 1), C becomes sign bit of ((~a & b) | (b & r) | (~a & r)).
- R5: For subtract (op = 1), V becomes sign bit of ((a & ~b & ~r) | (~a & b & r)).
- R6: For every class, N takes the result's sign bit and Z is set exactly when the result is zero. With wide_sel = 0 only result bits 7..0 count. With wide_sel = 1 all 16 bits count.
- R7: For test (op = 2), V is cleared, N and Z update, and C keeps its previous value.
- R8: For shift (op = 3), C takes `shift_cout` and V becomes the new N XOR the new C.
- R9: When `upd_en` is low, `ccr_q` does not change, whatever the other inputs are.
- R10: Bits 7..4 of `ccr_q` keep their reset value 0xD in every cycle after reset.
- R11: The register updates on the rising clock edge at which `upd_en` is high, and the new value appears on `ccr_q` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en | input | 1 | Writes the selected flags when high |
| op | input | 2 | Operation class: 0 add, 1 subtract, 2 test, 3 shift |
| wide_sel | input | 1 | 0 selects 8-bit flags, 1 selects 16-bit flags |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | input | 16 | Result of the operation |
| shift_cout | input | 1 | Bit shifted out by a shift operation |
| ccr_q | output | 8 | Condition code register |

## Verification
The hardest case to reach is one where the test class must keep a carry that an earlier step left set. A test after a step that cleared C cannot tell keeping C apart from clearing it. The vector table therefore puts each test right after an add, subtract or shift that leaves C at 1 in some places and at 0 in others. A second hard case is a narrow result whose low byte is zero while its upper bits are not. This is paired with a wide result in which only the low byte is zero, so that Z shows which width was selected.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
   typedef enum logic [1:0] {
      OPC_ADD = 2'd0,
      OPC_SUB = 2'd1,
      OPC_TST = 2'd2,
      OPC_SHF = 2'd3
   } opc_e;

   // positions of the low flags inside the register
   localparam int unsigned BIT_C = 0;
   localparam int unsigned BIT_V = 1;
   localparam int unsigned BIT_Z = 2;
   localparam int unsigned BIT_N = 3;

   localparam logic [7:0] CCR_RESET = 8'hD0;

   // which of {N,Z,V,C} each class writes
   function automatic logic [3:0] write_mask(opc_e opc);
      case (opc)
         OPC_TST: write_mask = 4'b1110;
         default: write_mask = 4'b1111;
      endcase
   endfunction
endpackage

// File: rtl/ccg_width_flags.sv
module ccg_width_flags
   import ccg_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  opc_e           opc,
   input  logic           a_sgn,
   input  logic           b_sgn,
   input  logic [W-1:0]   res,
   input  logic           sh_out,
   output logic [3:0]     nzvc
);
   logic r_sgn;
   logic zero;
   logic c_new;
   logic v_new;

   assign r_sgn = res[W-1];
   assign zero  = (res == '0);

   always_comb begin
      c_new = 1'b0;
      v_new = 1'b0;
      case (opc)
         OPC_ADD: begin
            c_new = (a_sgn & b_sgn) | (b_sgn & ~r_sgn) | (a_sgn & ~r_sgn);
            v_new = (a_sgn & b_sgn & ~r_sgn) | (~a_sgn & ~b_sgn & r_sgn);
         end
         OPC_SUB: begin
            c_new = (~a_sgn & b_sgn) | (b_sgn & r_sgn) | (~a_sgn & r_sgn);
            v_new = (a_sgn & ~b_sgn & ~r_sgn) | (~a_sgn & b_sgn & r_sgn);
         end
         OPC_TST: begin
            c_new = 1'b0;
            v_new = 1'b0;
         end
         OPC_SHF: begin
            c_new = sh_out;
            v_new = r_sgn ^ sh_out;
         end
         default: begin
            c_new = 1'b0;
            v_new = 1'b0;
         end
      endcase
   end

   assign nzvc = {r_sgn, zero, v_new, c_new};
endmodule

// File: rtl/ccg_ccr_store.sv
module ccg_ccr_store
   import ccg_pkg::*;
#(
   parameter logic [7:0] RST_VAL = CCR_RESET
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [3:0] wr_mask,
   input  logic [3:0] nzvc_new,
   output logic [7:0] ccr
);
   logic [3:0] low_q;
   logic [3:0] low_d;

   assign low_d = (low_q & ~wr_mask) | (nzvc_new & wr_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_q <= RST_VAL[3:0];
      else if (wr_en)
         low_q <= low_d;
   end

   // S X H I: held at their reset value, nothing in this block writes them
   assign ccr = {RST_VAL[7:4], low_q};
endmodule

// File: rtl/ccg_flag_unit.sv
module ccg_flag_unit
   import ccg_pkg::*;
#(
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned WIDE_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [1:0]        op,
   input  logic              wide_sel,
   input  logic [WIDE_W-1:0] opnd_a,
   input  logic [WIDE_W-1:0] opnd_b,
   input  logic [WIDE_W-1:0] result,
   input  logic              shift_cout,
   output logic [7:0]        ccr_q
);
   localparam int unsigned NUM_WIDTHS = 2;

   if (NARROW_W < 2) begin : g_bad_narrow
      $error("NARROW_W must be at least 2");
   end
   if (WIDE_W <= NARROW_W) begin : g_bad_wide
      $error("WIDE_W must exceed NARROW_W");
   end

   opc_e       opc;
   logic [3:0] nzvc_w [NUM_WIDTHS];
   logic [3:0] nzvc_sel;
   logic [3:0] mask;

   assign opc = opc_e'(op);

   for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
      localparam int unsigned W = (g == 0) ? NARROW_W : WIDE_W;
      ccg_width_flags #(.W(W)) u_flags (
         .opc    (opc),
         .a_sgn  (opnd_a[W-1]),
         .b_sgn  (opnd_b[W-1]),
         .res    (result[W-1:0]),
         .sh_out (shift_cout),
         .nzvc   (nzvc_w[g])
      );
   end

   assign nzvc_sel = wide_sel ? nzvc_w[1] : nzvc_w[0];
   assign mask     = write_mask(opc);

   ccg_ccr_store #(.RST_VAL(CCR_RESET)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (upd_en),
      .wr_mask  (mask),
      .nzvc_new (nzvc_sel),
      .ccr      (ccr_q)
   );
endmodule

// File: rtl/ccg_flag_unit_chk.sv
module ccg_flag_unit_chk #(
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned WIDE_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_en,
   input logic [1:0]        op,
   input logic              wide_sel,
   input logic [WIDE_W-1:0] result,
   input logic              shift_cout,
   input logic [7:0]        ccr_q
);
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(ccr_q)); // R9

   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      ccr_q[7:4] == 4'hD); // R10

   AST_TST_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op == 2'd2) |=> !ccr_q[1]); // R7

   AST_TST_C_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op == 2'd2) |=> ccr_q[0] == $past(ccr_q[0])); // R7

   AST_SHF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op == 2'd3) |=> ccr_q[0] == $past(shift_cout)); // R8

   AST_SHF_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op == 2'd3) |=> ccr_q[1] == (ccr_q[3] ^ ccr_q[0])); // R8

   AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wide_sel) |=> ccr_q[2] == ($past(result[NARROW_W-1:0]) == '0)); // R6

   AST_NEG_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && wide_sel) |=> ccr_q[3] == $past(result[WIDE_W-1])); // R6
endmodule

bind ccg_flag_unit ccg_flag_unit_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_en     (upd_en),
   .op         (op),
   .wide_sel   (wide_sel),
   .result     (result),
   .shift_cout (shift_cout),
   .ccr_q      (ccr_q)
);

// File: tb/ccg_flag_unit_test.sv
module ccg_flag_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_en = 1'b0;
   logic [1:0]  op = 2'd0;
   logic        wide_sel = 1'b0;
   logic [15:0] opnd_a = '0;
   logic [15:0] opnd_b = '0;
   logic [15:0] result = '0;
   logic        shift_cout = 1'b0;
   logic [7:0]  ccr_q;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ccg_flag_unit uut (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op(op), .wide_sel(wide_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
      .shift_cout(shift_cout), .ccr_q(ccr_q)
   );

   // {op, wide, a, b, r, shift_cout, expected NZVC}
   localparam int NV = 14;
   localparam logic [55:0] VEC [NV] = '{
      {2'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 1'b0, 4'b1010}, // R3 add V
      {2'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 4'b0101}, // R2 add C
      {2'd2, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0101}, // R7 keep C=1
      {2'd0, 1'b1, 16'h8000, 16'h8000, 16'h0000, 1'b0, 4'b0111}, // R2 R3 wide
      {2'd1, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 1'b0, 4'b1001}, // R4 borrow
      {2'd1, 1'b0, 16'h0080, 16'h0001, 16'h007F, 1'b0, 4'b0010}, // R5 sub V
      {2'd2, 1'b0, 16'h0000, 16'h0000, 16'h1280, 1'b0, 4'b1000}, // R7 keep C=0
      {2'd1, 1'b1, 16'h7FFF, 16'hFFFF, 16'h8000, 1'b0, 4'b1011}, // R4 R5 wide
      {2'd2, 1'b0, 16'h0000, 16'h0000, 16'h0100, 1'b0, 4'b0101}, // R6 narrow Z
      {2'd3, 1'b0, 16'h0000, 16'h0000, 16'h0080, 1'b0, 4'b1010}, // R8 V=N^C
      {2'd3, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'b0111}, // R8 C in
      {2'd3, 1'b1, 16'h0000, 16'h0000, 16'h8000, 1'b1, 4'b1001}, // R8 V=0
      {2'd0, 1'b1, 16'h1234, 16'h0001, 16'h1235, 1'b0, 4'b0000}, // R2 R3 clear
      {2'd1, 1'b1, 16'h0300, 16'h0200, 16'h0100, 1'b0, 4'b0000}  // R6 wide Z
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: ccr_q actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic apply(input logic en, input logic [1:0] o, input logic w,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] r, input logic sc);
      @(negedge clk);
      upd_en = en; op = o; wide_sel = w;
      opnd_a = a; opnd_b = b; result = r; shift_cout = sc;
      @(posedge clk);
      @(negedge clk);
      upd_en = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset value", ccr_q, 8'hD0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 upper bits after reset", ccr_q, 8'hD0);

      // R9: enable low with inputs that would set C, Z
      apply(1'b0, 2'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b1);
      check("R9 no update when disabled", ccr_q, 8'hD0);

      for (int i = 0; i < NV; i++) begin
         logic [55:0] v;
         v = VEC[i];
         apply(1'b1, v[55:54], v[53], v[52:37], v[36:21], v[20:5], v[4]);
         check($sformatf("R2-R8 vector %0d (R11 timing, R10 upper)", i),
               ccr_q, {4'hD, v[3:0]});
      end

      // R11: inputs present but latched only at the enabled edge
      @(negedge clk);
      op = 2'd3; wide_sel = 1'b0; result = 16'h0000; shift_cout = 1'b1;
      upd_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R11 no change before enabled edge", ccr_q, 8'hD0);
      upd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      upd_en = 1'b0;
      check("R11 value after enabled edge (R8)", ccr_q, 8'hD7);

      // R9 again from a non-reset state
      apply(1'b0, 2'd1, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 1'b0);
      check("R9 hold non-reset state", ccr_q, 8'hD7);

      // R7 test on wide negative keeps C=1
      apply(1'b1, 2'd2, 1'b1, 16'h0000, 16'h0000, 16'h8001, 1'b0);
      check("R7 test keeps C, clears V", ccr_q, 8'hD9);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", ccr_q, 8'hD0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule